// File: doc/BRIEF.md
# Floating-Point Status and Condition Update Unit

This block holds the status and control word of a floating-point pipe and updates it after every arithmetic operation the adder completes. The adder presents its raw exception flags, the class code of its result and two rounding indicators together with a one-cycle operation strobe. The unit does three things with them. It ORs the flags into sticky exception bits. It sets the exception summary bit only when a flag is newly raised. It overwrites the per-result fields. The rounding mode and the non-IEEE mode bit are stored in the same word and are driven back to the adder.

The invalid summary and the enabled-exception summary are not stored. They are derived from the sticky and enable bits, so they always agree with them. When an operation carries the record flag, a 4-bit condition field is loaded from the four summary bits of the updated word. Software can replace the whole word in one cycle through a write port. A write in the same cycle as an operation discards that operation.

Top module: `fp_status_unit`

## Requirements
- R1: Reset (rst_ni low) gives stat_o = 0x000004, rmode_o = 0, nonieee_o = 1 and cr_o = 0.
- R2: The word layout is: bits [1:0] rounding mode, bit 2 non-IEEE, bits 3/4/5/6 enables for invalid/overflow/underflow/inexact, bits [11:7] result class, bit 12 fraction-inexact, bit 13 fraction-rounded, bit 14 infinity-minus-infinity invalid, bit 15 signalling-NaN invalid, bit 16 inexact, bit 17 underflow, bit 18 overflow, bit 19 invalid summary, bit 20 enabled summary, bit 21 exception summary. On an accepted operation, flags_i bits 0..4 (inexact, underflow, overflow, infinity-minus-infinity, signalling NaN) are ORed into bits 16, 17, 18, 14 and 15; set sticky bits stay set.
- R3: An accepted operation sets bit 21 exactly when at least one flag raises a sticky bit that was 0. Otherwise bit 21 keeps its value.
- R4: Bit 20 always equals (bit19&bit3)|(bit18&bit4)|(bit17&bit5)|(bit16&bit6).
- R5: Bit 19 always equals bit14|bit15.
- R6: An accepted operation writes res_class_i into bits [11:7], res_fi_i into bit 12 and res_fr_i into bit 13.
- R7: An accepted operation with rec_i=1 loads cr_o, on the same edge, with {bit21, bit20, bit19, bit18} of the updated word, in that order from cr_o[3] down to cr_o[0]. At all other times cr_o holds its value.
- R8: An accepted operation updates the word in the same way whether rec_i is 0 or 1.
- R9: wr_en_i=1 loads bits [18:0] and bit 21 from wr_data_i. Data bits 19 and 20 are ignored, and R4/R5 recompute them. In that cycle any operation is discarded, including its effect on cr_o.
- R10: rmode_o equals bits [1:0] of the word and nonieee_o equals bit 2.
- R11: With neither op_valid_i nor wr_en_i asserted, stat_o and cr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Arithmetic operation completed this cycle |
| rec_i | input | 1 | Record form: also load the condition field |
| flags_i | input | 5 | Raw flags: inexact, underflow, overflow, inf-minus-inf, signalling NaN |
| res_class_i | input | 5 | Class code of the result |
| res_fr_i | input | 1 | Result fraction was rounded up |
| res_fi_i | input | 1 | Result is inexact |
| wr_en_i | input | 1 | Software write of the whole word |
| wr_data_i | input | 22 | Word to write |
| stat_o | output | 22 | Current status and control word |
| rmode_o | output | 2 | Rounding mode to the adder |
| nonieee_o | output | 1 | Non-IEEE mode to the adder |
| cr_o | output | 4 | Condition field |

## Verification
The hardest state to reach is a word whose sticky bits are already set while the exception summary is clear. Operations alone can never produce it, because every raised sticky bit sets the summary. This state is where the difference between newly raised and already raised flags shows, and it can only be reached through the write port. The bench therefore preloads sixteen distinct words, with every mix of enables and sticky bits the pattern generator yields. After each preload it sweeps all 32 flag combinations with both values of the record flag, and it also drives a write and an operation in the same cycle.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  parameter int unsigned CLS_W  = 5;
  parameter int unsigned FLG_W  = 5;
  parameter int unsigned STAT_W = 22;
  parameter int unsigned CR_W   = 4;

  // flags_i bit indices
  parameter int unsigned FL_XX   = 0;
  parameter int unsigned FL_UX   = 1;
  parameter int unsigned FL_OX   = 2;
  parameter int unsigned FL_ISI  = 3;
  parameter int unsigned FL_SNAN = 4;

  // stored fields, bits [18:0] of the visible word
  typedef struct packed {
    logic             ox;
    logic             ux;
    logic             xx;
    logic             vx_snan;
    logic             vx_isi;
    logic             fr;
    logic             fi;
    logic [CLS_W-1:0] cls;
    logic             xe;
    logic             ue;
    logic             oe;
    logic             ve;
    logic             ni;
    logic [1:0]       rm;
  } fpsu_st_t;

  parameter int unsigned ST_W = $bits(fpsu_st_t);
  parameter int unsigned FX_BIT = STAT_W - 1;
endpackage

// File: rtl/fpsu_sticky.sv
module fpsu_sticky
  import fpsu_pkg::*;
(
  input  fpsu_st_t               st_i,
  input  logic                   fx_i,
  input  logic [FLG_W-1:0]       flags_i,
  input  logic [CLS_W-1:0]       cls_i,
  input  logic                   fr_i,
  input  logic                   fi_i,
  output fpsu_st_t               st_o,
  output logic                   fx_o
);
  logic [FLG_W-1:0] old_exc;
  logic [FLG_W-1:0] fresh;

  assign old_exc[FL_XX]   = st_i.xx;
  assign old_exc[FL_UX]   = st_i.ux;
  assign old_exc[FL_OX]   = st_i.ox;
  assign old_exc[FL_ISI]  = st_i.vx_isi;
  assign old_exc[FL_SNAN] = st_i.vx_snan;

  // only 0->1 transitions raise the summary
  assign fresh = flags_i & ~old_exc;

  always_comb begin
    st_o         = st_i;
    st_o.xx      = st_i.xx      | flags_i[FL_XX];
    st_o.ux      = st_i.ux      | flags_i[FL_UX];
    st_o.ox      = st_i.ox      | flags_i[FL_OX];
    st_o.vx_isi  = st_i.vx_isi  | flags_i[FL_ISI];
    st_o.vx_snan = st_i.vx_snan | flags_i[FL_SNAN];
    st_o.cls     = cls_i;
    st_o.fr      = fr_i;
    st_o.fi      = fi_i;
    fx_o         = fx_i | (|fresh);
  end
endmodule

// File: rtl/fpsu_summary.sv
module fpsu_summary
  import fpsu_pkg::*;
(
  input  fpsu_st_t st_i,
  output logic     vx_o,
  output logic     fex_o
);
  assign vx_o  = st_i.vx_isi | st_i.vx_snan;
  assign fex_o = (vx_o & st_i.ve) | (st_i.ox & st_i.oe)
               | (st_i.ux & st_i.ue) | (st_i.xx & st_i.xe);
endmodule

// File: rtl/fpsu_cr.sv
module fpsu_cr
  import fpsu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CR_W-1:0] val_i,
  output logic [CR_W-1:0] cr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cr_o <= '0;
    else if (load_i) cr_o <= val_i;
  end
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic                rec_i,
  input  logic [FLG_W-1:0]    flags_i,
  input  logic [CLS_W-1:0]    res_class_i,
  input  logic                res_fr_i,
  input  logic                res_fi_i,
  input  logic                wr_en_i,
  input  logic [STAT_W-1:0]   wr_data_i,
  output logic [STAT_W-1:0]   stat_o,
  output logic [1:0]          rmode_o,
  output logic                nonieee_o,
  output logic [CR_W-1:0]     cr_o
);
  localparam fpsu_st_t ST_RST = '{ni: 1'b1, default: '0};

  fpsu_st_t st_q, st_d, st_upd;
  logic     fx_q, fx_d, fx_upd;
  logic     vx_q, fex_q, vx_upd, fex_upd;
  logic     op_acc;

  assign op_acc = op_valid_i & ~wr_en_i;

  fpsu_sticky u_sticky (
    .st_i    (st_q),
    .fx_i    (fx_q),
    .flags_i (flags_i),
    .cls_i   (res_class_i),
    .fr_i    (res_fr_i),
    .fi_i    (res_fi_i),
    .st_o    (st_upd),
    .fx_o    (fx_upd)
  );

  fpsu_summary u_sum_cur (.st_i(st_q),   .vx_o(vx_q),   .fex_o(fex_q));
  fpsu_summary u_sum_nxt (.st_i(st_upd), .vx_o(vx_upd), .fex_o(fex_upd));

  always_comb begin
    st_d = st_q;
    fx_d = fx_q;
    if (wr_en_i) begin
      st_d = fpsu_st_t'(wr_data_i[ST_W-1:0]);
      fx_d = wr_data_i[FX_BIT];
    end else if (op_valid_i) begin
      st_d = st_upd;
      fx_d = fx_upd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RST;
      fx_q <= 1'b0;
    end else begin
      st_q <= st_d;
      fx_q <= fx_d;
    end
  end

  fpsu_cr u_cr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (op_acc & rec_i),
    .val_i  ({fx_upd, fex_upd, vx_upd, st_upd.ox}),
    .cr_o   (cr_o)
  );

  assign stat_o    = {fx_q, fex_q, vx_q, st_q};
  assign rmode_o   = st_q.rm;
  assign nonieee_o = st_q.ni;
endmodule

// File: rtl/fp_status_unit_chk.sv
module fp_status_unit_chk
  import fpsu_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                op_valid_i,
  input logic                rec_i,
  input logic [FLG_W-1:0]    flags_i,
  input logic [CLS_W-1:0]    res_class_i,
  input logic                wr_en_i,
  input logic [STAT_W-1:0]   wr_data_i,
  input logic [STAT_W-1:0]   stat_o,
  input logic [CR_W-1:0]     cr_o
);
  logic acc;
  logic [FLG_W-1:0] old_exc;
  assign acc     = op_valid_i && !wr_en_i;
  assign old_exc = {stat_o[15], stat_o[14], stat_o[18], stat_o[17], stat_o[16]};

  assert_ox_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (flags_i[FL_OX] || stat_o[18])) |=> stat_o[18]);

  assert_fx_raise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && |(flags_i & ~old_exc)) |=> stat_o[FX_BIT]);

  assert_fx_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(|(flags_i & ~old_exc))) |=> $stable(stat_o[FX_BIT]));

  assert_class_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> stat_o[11:7] == $past(res_class_i));

  assert_cr_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rec_i) |=> cr_o == {stat_o[21], stat_o[20], stat_o[19], stat_o[18]});

  assert_cr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && rec_i) |=> $stable(cr_o));

  assert_wr_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (stat_o[18:0] == $past(wr_data_i[18:0]))
                && (stat_o[21] == $past(wr_data_i[21])));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !wr_en_i) |=> $stable(stat_o));
endmodule

bind fp_status_unit fp_status_unit_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .rec_i       (rec_i),
  .flags_i     (flags_i),
  .res_class_i (res_class_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .stat_o      (stat_o),
  .cr_o        (cr_o)
);

// File: tb/fp_status_unit_tb_top.sv
module fp_status_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        rec_i = 1'b0;
  logic [4:0]  flags_i = '0;
  logic [4:0]  res_class_i = '0;
  logic        res_fr_i = 1'b0;
  logic        res_fi_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [21:0] wr_data_i = '0;
  logic [21:0] stat_o;
  logic [1:0]  rmode_o;
  logic        nonieee_o;
  logic [3:0]  cr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [21:0] exp_s;
  logic [3:0]  exp_cr;

  always #2 clk_i = ~clk_i;

  fp_status_unit dut_i (.*);

  function automatic logic [21:0] fixup(input logic [21:0] s);
    logic [21:0] r;
    r = s;
    r[19] = r[14] | r[15];
    r[20] = (r[19] & r[3]) | (r[18] & r[4]) | (r[17] & r[5]) | (r[16] & r[6]);
    return r;
  endfunction

  function automatic logic [21:0] model_op(input logic [21:0] s, input logic [4:0] f,
                                           input logic [4:0] cls, input logic fr, input logic fi);
    logic [21:0] r;
    logic [4:0]  was;
    r   = s;
    was = {s[15], s[14], s[18], s[17], s[16]};
    r[16] = r[16] | f[0];
    r[17] = r[17] | f[1];
    r[18] = r[18] | f[2];
    r[14] = r[14] | f[3];
    r[15] = r[15] | f[4];
    if (|(f & ~was)) r[21] = 1'b1;
    r[11:7] = cls;
    r[12]   = fi;
    r[13]   = fr;
    return fixup(r);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_word();
    chk("R2 sticky", 32'(stat_o[18:14]), 32'(exp_s[18:14]));
    chk("R3 fx",     32'(stat_o[21]),    32'(exp_s[21]));
    chk("R4 fex",    32'(stat_o[20]),    32'(exp_s[20]));
    chk("R5 vx",     32'(stat_o[19]),    32'(exp_s[19]));
    chk("R6 result", 32'(stat_o[13:7]),  32'(exp_s[13:7]));
    chk("R10 mode",  32'({rmode_o, nonieee_o}), 32'({exp_s[1:0], exp_s[2]}));
  endtask

  task automatic do_write(input logic [21:0] wd);
    wr_en_i = 1'b1; wr_data_i = wd;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    exp_s = fixup({wd[21], 2'b00, wd[18:0]});
    chk("R9 write", 32'(stat_o), 32'(exp_s));
    chk("R9 cr", 32'(cr_o), 32'(exp_cr));
    chk_word();
  endtask

  task automatic do_op(input logic [4:0] f, input logic [4:0] cls, input logic fr,
                       input logic fi, input logic rec);
    op_valid_i = 1'b1; flags_i = f; res_class_i = cls;
    res_fr_i = fr; res_fi_i = fi; rec_i = rec;
    @(negedge clk_i);
    op_valid_i = 1'b0; rec_i = 1'b0; flags_i = '0;
    exp_s = model_op(exp_s, f, cls, fr, fi);
    if (rec) exp_cr = {exp_s[21], exp_s[20], exp_s[19], exp_s[18]};
    chk_word();
    chk(rec ? "R7 cr load" : "R8 cr hold", 32'(cr_o), 32'(exp_cr));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [21:0] wd;
    repeat (3) @(negedge clk_i);
    chk("R1 stat", 32'(stat_o), 32'h4);
    chk("R1 cr", 32'(cr_o), 32'h0);
    chk("R1 mode", 32'({rmode_o, nonieee_o}), 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_s = 22'h4; exp_cr = '0;

    // op straight out of reset
    do_op(5'b00101, 5'd3, 1'b1, 1'b1, 1'b1);

    for (int p = 0; p < 16; p++) begin
      wd = 22'((p * 32'h0009_E3B5) ^ (p << 14) ^ 32'h0018_0000);
      if (p == 5) wd = 22'h07C078;  // stickies set, summary clear, all enabled
      do_write(wd);
      for (int f = 0; f < 32; f++) begin
        do_op(5'(f), 5'(f ^ p), f[0] ^ p[1], f[1], f[0] ^ p[0]);
        if ((f % 8) == 7) begin
          @(negedge clk_i);
          chk("R11 idle stat", 32'(stat_o), 32'(exp_s));
          chk("R11 idle cr", 32'(cr_o), 32'(exp_cr));
        end
      end
    end

    // FX must stay clear when every flag hits an already-set sticky bit
    do_write(22'h07C000);
    do_op(5'h1F, 5'd9, 1'b0, 1'b1, 1'b1);
    chk("R3 no re-raise", 32'(stat_o[21]), 32'h0);

    // write and op in the same cycle: op discarded, cr untouched
    do_op(5'h00, 5'd1, 1'b0, 1'b0, 1'b1);
    op_valid_i = 1'b1; rec_i = 1'b1; flags_i = 5'h1F; res_class_i = 5'd31;
    do_write(22'h000003);
    op_valid_i = 1'b0; rec_i = 1'b0; flags_i = '0;
    chk("R9 prio fx", 32'(stat_o[21]), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule